// File: doc/BRIEF.md
# Instruction Length Decoder

The block examines a fixed window of bytes from a 32-bit protected-mode integer instruction stream. Byte 0 of the window is the first byte of an instruction. In a single evaluation it finds where the prefix run ends and whether the opcode uses the two-byte escape. It then classifies the opcode to decide whether a ModR/M byte and an immediate follow. From the addressing fields it works out whether a SIB byte and a displacement are present. Adding these parts gives the instruction length in bytes.

A front end sets `i_vld` together with a window. On the next clock edge, every field of the decode result is captured into output registers, and `o_vld` pulses for one cycle. The outputs keep their values until the next strobe. An instruction that would be longer than the architectural limit of 15 bytes is reported with the error flag set and a length of zero. The front end uses the length to advance to the next boundary.

`i_def16` selects a 16-bit default for both operand size and address size. The operand-size prefix and the address-size prefix each flip their own size, independently of the other.

Top module: `ild_top`

## Requirements
- R1: After reset every output is zero. `o_vld` is high exactly in the cycle after a cycle with `i_vld` high. The result fields are loaded only on a strobe and keep their values while `i_vld` is low.
- R2: `o_npfx` counts the leading bytes that belong to the prefix set {26, 2E, 36, 3E, 64, 65, 66, 67, F0, F2, F3} (hex). Counting stops at the first byte outside that set. A prefix byte that comes after a non-prefix byte is not counted.
- R3: The first non-prefix byte 0F makes `o_two_byte` 1, and the byte after it is reported on `o_opcode` as the opcode. Otherwise `o_two_byte` is 0 and the first non-prefix byte is the opcode.
- R4: The one-byte map has a ModR/M byte for these opcodes: 00-3F whose low three bits are 0 to 3, 62, 63, 69, 6B, 80-8F, C0, C1, C4-C7, D0-D3, D8-DF, F6, F7, FE and FF. The two-byte map has a ModR/M byte except for these opcodes: 04-0C, 0E, 30-3F, 77, 80-8F, A0-A2, A8-AA and C8-CF.
- R5: With 32-bit addressing, a ModR/M mod field (bits 7:6) of 1 gives a 1-byte displacement and mod 2 gives 4 bytes. Mod 0 with r/m (bits 2:0) equal to 5 gives 4 bytes. Mod 3 gives no displacement.
- R6: With 32-bit addressing, a SIB byte follows ModR/M when r/m is 4 and mod is not 3. With mod 0, a SIB base field (bits 2:0) of 5 adds a 4-byte displacement.
- R7: With 16-bit addressing (`i_def16` XOR the presence of prefix 67), there is never a SIB byte. Mod 1 gives 1 displacement byte and mod 2 gives 2 bytes. Mod 0 with r/m 6 gives 2 bytes.
- R8: A 1-byte immediate comes with these one-byte opcodes: 04/0C/../3C, 6A, 6B, 70-7F, 80, 82, 83, A8, B0-B7, C0, C1, C6, CD, D4, D5, E0-E7 and EB. The two-byte opcodes with a 1-byte immediate are 0F, 70-73, A4, AC, BA and C2-C6 except C3. C2 and CA take 2 bytes and C8 takes 3.
- R9: A full-size immediate is 4 bytes, or 2 bytes under 16-bit operand size (`i_def16` XOR the presence of prefix 66). It comes with 05/0D/../3D, 68, 69, 81, A9, B8-BF, C7, E8, E9 and the two-byte 80-8F. A far pointer (9A, EA) takes a full-size immediate plus 2 bytes.
- R10: One-byte opcodes A0-A3 have no ModR/M byte and carry a displacement of address size (4 bytes, or 2 bytes under 16-bit addressing).
- R11: `o_len` is the sum of the prefix count, the opcode bytes, the ModR/M and SIB bytes, and the displacement and immediate sizes. When that sum exceeds 15, `o_err` is 1 and `o_len` is 0.
- R12: F6 and F7 carry an immediate (1 byte for F6, full size for F7) only when the ModR/M reg field (bits 5:3) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_vld | input | 1 | Window valid strobe |
| i_def16 | input | 1 | Default operand and address size is 16 bits |
| i_win | input | 120 | Byte window, byte k at bits 8k+7:8k |
| o_vld | output | 1 | Result captured this cycle |
| o_npfx | output | 4 | Prefix byte count |
| o_two_byte | output | 1 | Opcode uses the 0F escape |
| o_opcode | output | 8 | Opcode byte (after the escape if present) |
| o_has_modrm | output | 1 | ModR/M byte present |
| o_has_sib | output | 1 | SIB byte present |
| o_disp_sz | output | 3 | Displacement bytes |
| o_imm_sz | output | 3 | Immediate bytes |
| o_len | output | 4 | Total length, 0 on error |
| o_err | output | 1 | Length exceeds 15 |

## Verification
The bench builds the block with its default 15-byte window and 15-byte limit, so every legal instruction fits and overflow can be reached. With this setting, one sweep covers every ModR/M value with two SIB base values, under all four combinations of the two size prefixes and both defaults, for both a plain opcode and a full-immediate opcode. A second sweep lengthens the prefix run one byte at a time up to a full window. Directed opcodes from both maps fill in the immediate classes, the absolute-address forms and the length-limit boundary.

// File: rtl/ild_pkg.sv
package ild_pkg;

  typedef enum logic [2:0] {
    IMM_NONE  = 3'd0,
    IMM_B8    = 3'd1,
    IMM_W16   = 3'd2,
    IMM_FULL  = 3'd3,
    IMM_ENTER = 3'd4,
    IMM_FAR   = 3'd5
  } imm_cls_e;

  localparam logic [7:0] ESC_2B   = 8'h0F;
  localparam logic [7:0] PFX_OPSZ = 8'h66;
  localparam logic [7:0] PFX_ADSZ = 8'h67;

  function automatic logic is_prefix(input logic [7:0] b);
    case (b)
      8'hF0, 8'hF2, 8'hF3,
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67: is_prefix = 1'b1;
      default:      is_prefix = 1'b0;
    endcase
  endfunction

  function automatic logic one_map_modrm(input logic [7:0] op);
    logic r;
    r = 1'b0;
    if (op[7:6] == 2'b00 && op[2] == 1'b0) r = 1'b1;
    if (op[7:4] == 4'h8) r = 1'b1;
    if (op[7:3] == 5'b11011) r = 1'b1;
    case (op)
      8'h62, 8'h63, 8'h69, 8'h6B,
      8'hC0, 8'hC1, 8'hC4, 8'hC5, 8'hC6, 8'hC7,
      8'hD0, 8'hD1, 8'hD2, 8'hD3,
      8'hF6, 8'hF7, 8'hFE, 8'hFF: r = 1'b1;
      default: ;
    endcase
    return r;
  endfunction

  function automatic imm_cls_e one_map_imm(input logic [7:0] op, input logic [2:0] reg_f);
    imm_cls_e c;
    c = IMM_NONE;
    if (op[7:6] == 2'b00 && op[2:0] == 3'd4) c = IMM_B8;
    if (op[7:6] == 2'b00 && op[2:0] == 3'd5) c = IMM_FULL;
    if (op[7:4] == 4'h7) c = IMM_B8;
    if (op[7:3] == 5'b10110) c = IMM_B8;
    if (op[7:3] == 5'b10111) c = IMM_FULL;
    if (op[7:3] == 5'b11100) c = IMM_B8;
    case (op)
      8'h6A, 8'h6B, 8'h80, 8'h82, 8'h83, 8'hA8, 8'hC0, 8'hC1,
      8'hC6, 8'hCD, 8'hD4, 8'hD5, 8'hEB:       c = IMM_B8;
      8'h68, 8'h69, 8'h81, 8'hA9, 8'hC7,
      8'hE8, 8'hE9:                            c = IMM_FULL;
      8'hC2, 8'hCA:                            c = IMM_W16;
      8'hC8:                                   c = IMM_ENTER;
      8'h9A, 8'hEA:                            c = IMM_FAR;
      8'hF6:                                   c = (reg_f == 3'd0) ? IMM_B8 : IMM_NONE;
      8'hF7:                                   c = (reg_f == 3'd0) ? IMM_FULL : IMM_NONE;
      default: ;
    endcase
    return c;
  endfunction

  function automatic logic two_map_modrm(input logic [7:0] op);
    logic none;
    none = 1'b0;
    if (op[7:4] == 4'h0 && op[3:0] >= 4'h4 && op[3:0] <= 4'hC) none = 1'b1;
    if (op == 8'h0E || op == 8'h77) none = 1'b1;
    if (op[7:4] == 4'h3 || op[7:4] == 4'h8) none = 1'b1;
    if (op[7:3] == 5'b11001) none = 1'b1;
    case (op)
      8'hA0, 8'hA1, 8'hA2, 8'hA8, 8'hA9, 8'hAA: none = 1'b1;
      default: ;
    endcase
    return !none;
  endfunction

  function automatic imm_cls_e two_map_imm(input logic [7:0] op);
    imm_cls_e c;
    c = IMM_NONE;
    if (op[7:2] == 6'b011100) c = IMM_B8;
    if (op[7:4] == 4'h8) c = IMM_FULL;
    case (op)
      8'h0F, 8'hA4, 8'hAC, 8'hBA, 8'hC2, 8'hC4, 8'hC5, 8'hC6: c = IMM_B8;
      default: ;
    endcase
    return c;
  endfunction

  function automatic logic [2:0] imm_bytes(input imm_cls_e c, input logic osz16);
    case (c)
      IMM_B8:    imm_bytes = 3'd1;
      IMM_W16:   imm_bytes = 3'd2;
      IMM_FULL:  imm_bytes = osz16 ? 3'd2 : 3'd4;
      IMM_ENTER: imm_bytes = 3'd3;
      IMM_FAR:   imm_bytes = osz16 ? 3'd4 : 3'd6;
      default:   imm_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ild_pfx_scan.sv
module ild_pfx_scan #(
  parameter int WIN_BYTES = 15,
  localparam int IDX_W = $clog2(WIN_BYTES + 18)
) (
  input  logic [WIN_BYTES*8-1:0] i_win,
  output logic [IDX_W-1:0]       o_npfx,
  output logic                   o_opsz_seen,
  output logic                   o_adsz_seen,
  output logic                   o_run_full
);
  import ild_pkg::*;

  logic [WIN_BYTES-1:0] byte_is_pfx;
  logic [WIN_BYTES:0]   still_in_run;

  // per-byte prefix detection
  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_pfx
    assign byte_is_pfx[g] = is_prefix(i_win[g*8 +: 8]);
  end

  // the run continues only while every earlier byte was a prefix
  assign still_in_run[0] = 1'b1;
  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_run
    assign still_in_run[g+1] = still_in_run[g] & byte_is_pfx[g];
  end

  always_comb begin
    o_npfx      = '0;
    o_opsz_seen = 1'b0;
    o_adsz_seen = 1'b0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (still_in_run[i+1]) begin
        o_npfx = o_npfx + IDX_W'(1);
        if (i_win[i*8 +: 8] == PFX_OPSZ) o_opsz_seen = 1'b1;
        if (i_win[i*8 +: 8] == PFX_ADSZ) o_adsz_seen = 1'b1;
      end
    end
  end

  assign o_run_full = still_in_run[WIN_BYTES];

endmodule

// File: rtl/ild_opc_class.sv
module ild_opc_class (
  input  logic                i_two,
  input  logic [7:0]          i_opc,
  input  logic [2:0]          i_reg,
  output logic                o_has_modrm,
  output ild_pkg::imm_cls_e   o_imm_cls,
  output logic                o_moffs
);
  import ild_pkg::*;

  always_comb begin
    if (i_two) begin
      o_has_modrm = two_map_modrm(i_opc);
      o_imm_cls   = two_map_imm(i_opc);
      o_moffs     = 1'b0;
    end else begin
      o_has_modrm = one_map_modrm(i_opc);
      o_imm_cls   = one_map_imm(i_opc, i_reg);
      o_moffs     = (i_opc[7:2] == 6'b101000);
    end
  end

endmodule

// File: rtl/ild_addr_calc.sv
module ild_addr_calc (
  input  logic       i_has_modrm,
  input  logic       i_moffs,
  input  logic       i_a16,
  input  logic [1:0] i_mod,
  input  logic [2:0] i_rm,
  input  logic [2:0] i_sib_base,
  output logic       o_has_sib,
  output logic [2:0] o_disp_sz
);
  logic sib_form;
  logic direct32;
  logic direct16;
  logic sib_nobase;

  assign sib_form   = i_has_modrm && !i_a16 && (i_mod != 2'd3) && (i_rm == 3'd4);
  assign direct32   = !i_a16 && (i_mod == 2'd0) && (i_rm == 3'd5);
  assign direct16   = i_a16 && (i_mod == 2'd0) && (i_rm == 3'd6);
  assign sib_nobase = sib_form && (i_mod == 2'd0) && (i_sib_base == 3'd5);

  always_comb begin
    o_has_sib = 1'b0;
    o_disp_sz = 3'd0;
    if (i_moffs) begin
      o_disp_sz = i_a16 ? 3'd2 : 3'd4;
    end else if (i_has_modrm) begin
      o_has_sib = sib_form;
      case (i_mod)
        2'd1:    o_disp_sz = 3'd1;
        2'd2:    o_disp_sz = i_a16 ? 3'd2 : 3'd4;
        2'd0: begin
          if (direct32 || sib_nobase) o_disp_sz = 3'd4;
          else if (direct16)          o_disp_sz = 3'd2;
        end
        default: o_disp_sz = 3'd0;
      endcase
    end
  end

endmodule

// File: rtl/ild_top.sv
module ild_top #(
  parameter int WIN_BYTES = 15,
  parameter int MAX_LEN   = 15,
  localparam int IDX_W    = $clog2(WIN_BYTES + 18),
  localparam int NPFX_W   = $clog2(WIN_BYTES + 1),
  localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   i_vld,
  input  logic                   i_def16,
  input  logic [WIN_BYTES*8-1:0] i_win,
  output logic                   o_vld,
  output logic [NPFX_W-1:0]      o_npfx,
  output logic                   o_two_byte,
  output logic [7:0]             o_opcode,
  output logic                   o_has_modrm,
  output logic                   o_has_sib,
  output logic [2:0]             o_disp_sz,
  output logic [2:0]             o_imm_sz,
  output logic [LEN_W-1:0]       o_len,
  output logic                   o_err
);
  import ild_pkg::*;

  function automatic logic [7:0] win_byte(input logic [WIN_BYTES*8-1:0] w,
                                          input logic [IDX_W-1:0] idx);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < WIN_BYTES; i++)
      if (idx == IDX_W'(i)) r = w[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] part_sum(
      input logic [IDX_W-1:0] npfx, input logic two, input logic modrm,
      input logic sib, input logic [2:0] disp, input logic [2:0] imm);
    return npfx + IDX_W'(two ? 2 : 1) + IDX_W'(modrm) + IDX_W'(sib)
         + IDX_W'(disp) + IDX_W'(imm);
  endfunction

  // prefix stage
  logic [IDX_W-1:0] npfx;
  logic             opsz_seen, adsz_seen, run_full;

  ild_pfx_scan #(.WIN_BYTES(WIN_BYTES)) u_pfx (
    .i_win       (i_win),
    .o_npfx      (npfx),
    .o_opsz_seen (opsz_seen),
    .o_adsz_seen (adsz_seen),
    .o_run_full  (run_full)
  );

  // opcode stage
  logic [7:0]       lead_byte, opcode;
  logic             two_byte;
  logic [IDX_W-1:0] modrm_idx;
  logic [7:0]       modrm_b, sib_b;

  assign lead_byte = win_byte(i_win, npfx);
  assign two_byte  = (lead_byte == ESC_2B);
  assign opcode    = two_byte ? win_byte(i_win, npfx + IDX_W'(1)) : lead_byte;
  assign modrm_idx = npfx + IDX_W'(two_byte ? 2 : 1);
  assign modrm_b   = win_byte(i_win, modrm_idx);
  assign sib_b     = win_byte(i_win, modrm_idx + IDX_W'(1));

  logic     has_modrm, moffs;
  imm_cls_e imm_cls;

  ild_opc_class u_cls (
    .i_two       (two_byte),
    .i_opc       (opcode),
    .i_reg       (modrm_b[5:3]),
    .o_has_modrm (has_modrm),
    .o_imm_cls   (imm_cls),
    .o_moffs     (moffs)
  );

  // effective sizes: each prefix flips its own default
  logic osz16, a16;
  assign osz16 = i_def16 ^ opsz_seen;
  assign a16   = i_def16 ^ adsz_seen;

  logic       has_sib;
  logic [2:0] disp_sz;

  ild_addr_calc u_addr (
    .i_has_modrm (has_modrm),
    .i_moffs     (moffs),
    .i_a16       (a16),
    .i_mod       (modrm_b[7:6]),
    .i_rm        (modrm_b[2:0]),
    .i_sib_base  (sib_b[2:0]),
    .o_has_sib   (has_sib),
    .o_disp_sz   (disp_sz)
  );

  logic [2:0]       imm_sz;
  logic [IDX_W-1:0] len_full;
  logic             len_over;

  assign imm_sz   = imm_bytes(imm_cls, osz16);
  assign len_full = part_sum(npfx, two_byte, has_modrm, has_sib, disp_sz, imm_sz);
  assign len_over = (len_full > IDX_W'(MAX_LEN)) || run_full;

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld       <= 1'b0;
      o_npfx      <= '0;
      o_two_byte  <= 1'b0;
      o_opcode    <= '0;
      o_has_modrm <= 1'b0;
      o_has_sib   <= 1'b0;
      o_disp_sz   <= '0;
      o_imm_sz    <= '0;
      o_len       <= '0;
      o_err       <= 1'b0;
    end else begin
      o_vld <= i_vld;
      if (i_vld) begin
        o_npfx      <= NPFX_W'(npfx);
        o_two_byte  <= two_byte;
        o_opcode    <= opcode;
        o_has_modrm <= has_modrm;
        o_has_sib   <= has_sib;
        o_disp_sz   <= disp_sz;
        o_imm_sz    <= imm_sz;
        o_len       <= len_over ? '0 : LEN_W'(len_full);
        o_err       <= len_over;
      end
    end
  end

  // checks on the capture path
  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    i_vld |=> o_vld);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !i_vld |=> !o_vld);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !i_vld |=> ($stable(o_len) && $stable(o_opcode) && $stable(o_err)));
  p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && o_err) |-> (o_len == '0));
  p_len_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && !o_err) |-> (o_len > LEN_W'(o_npfx)));
  p_escape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && !o_err && o_two_byte) |-> (o_len >= LEN_W'(o_npfx) + LEN_W'(2)));
  p_sib_modrm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && o_has_sib) |-> o_has_modrm);
  p_a16_nosib_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && a16) |-> !has_sib);
  p_moffs_disp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && moffs) |-> (disp_sz != 3'd0 && !has_modrm));

endmodule

// File: tb/ild_top_tb.sv
module ild_top_tb;
  localparam int WB = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, i_vld, i_def16;
  logic [WB*8-1:0] i_win;
  logic          o_vld, o_two_byte, o_has_modrm, o_has_sib, o_err;
  logic [3:0]    o_npfx, o_len;
  logic [7:0]    o_opcode;
  logic [2:0]    o_disp_sz, o_imm_sz;

  ild_top u_dut (
    .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_def16(i_def16), .i_win(i_win),
    .o_vld(o_vld), .o_npfx(o_npfx), .o_two_byte(o_two_byte), .o_opcode(o_opcode),
    .o_has_modrm(o_has_modrm), .o_has_sib(o_has_sib), .o_disp_sz(o_disp_sz),
    .o_imm_sz(o_imm_sz), .o_len(o_len), .o_err(o_err)
  );

  int total = 0;
  int bad   = 0;
  logic [7:0] bq [WB];
  int nb;

  task automatic clr();
    nb = 0;
  endtask

  task automatic put(input logic [7:0] b);
    if (nb < WB) bq[nb] = b;
    nb++;
  endtask

  // drive at a falling edge, capture at the rising edge, sample at the next falling edge
  task automatic fire(input logic d16);
    for (int i = 0; i < WB; i++) i_win[i*8 +: 8] = (i < nb) ? bq[i] : 8'hCC;
    i_def16 = d16;
    i_vld   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    i_vld = 1'b0;
  endtask

  task automatic expect_all(input string tag, input int np, input bit two,
                            input logic [7:0] opc, input bit mr, input bit sb,
                            input int dsp, input int imm);
    int  len;
    bit  er, miss;
    len  = np + (two ? 2 : 1) + int'(mr) + int'(sb) + dsp + imm;
    er   = (len > 15);
    miss = (o_vld !== 1'b1) || (o_err !== er) || (o_len !== (er ? 4'd0 : 4'(len)));
    if (!er)
      miss = miss || (o_npfx !== 4'(np)) || (o_two_byte !== two) || (o_opcode !== opc) ||
             (o_has_modrm !== mr) || (o_has_sib !== sb) ||
             (o_disp_sz !== 3'(dsp)) || (o_imm_sz !== 3'(imm));
    total++;
    if (miss) begin
      bad++;
      $display("FAIL %s: got vld=%0b np=%0d two=%0b op=%h mr=%0b sib=%0b d=%0d i=%0d len=%0d err=%0b | exp np=%0d two=%0b op=%h mr=%0b sib=%0b d=%0d i=%0d len=%0d err=%0b",
               tag, o_vld, o_npfx, o_two_byte, o_opcode, o_has_modrm, o_has_sib,
               o_disp_sz, o_imm_sz, o_len, o_err,
               np, two, opc, mr, sb, dsp, imm, er ? 0 : len, er);
    end
  endtask

  // addressing expectation, written from the mod/r-m tables
  task automatic addr_model(input logic [7:0] m, input logic [7:0] s, input bit a16,
                            output bit sb, output int dsp);
    sb  = 1'b0;
    dsp = 0;
    case (m[7:6])
      2'd3: dsp = 0;
      2'd1: begin sb = !a16 && (m[2:0] == 3'd4); dsp = 1; end
      2'd2: begin sb = !a16 && (m[2:0] == 3'd4); dsp = a16 ? 2 : 4; end
      default: begin
        if (a16) dsp = (m[2:0] == 3'd6) ? 2 : 0;
        else begin
          sb  = (m[2:0] == 3'd4);
          dsp = ((m[2:0] == 3'd5) || (sb && s[2:0] == 3'd5)) ? 4 : 0;
        end
      end
    endcase
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got running exp finished");
    report();
  end

  logic [7:0] pfx_cycle [11] = '{8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
                                 8'h26, 8'h64, 8'h65, 8'h66, 8'h67};

  initial begin
    bit sb;
    int dsp;
    rst_n = 1'b0; i_vld = 1'b0; i_def16 = 1'b0; i_win = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (o_vld !== 0 || o_len !== 0 || o_err !== 0 || o_opcode !== 0 || o_npfx !== 0) begin
      bad++;
      $display("FAIL R1 reset: got vld=%0b len=%0d err=%0b exp 0 0 0", o_vld, o_len, o_err);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 prefix run sweep, including a full window of prefixes (R11 overflow)
    for (int k = 0; k <= WB; k++) begin
      clr();
      for (int j = 0; j < k; j++) put(pfx_cycle[j % 11]);
      put(8'h90);
      fire(1'b0);
      expect_all("R2 R11 prefix run", k, 1'b0, 8'h90, 1'b0, 1'b0, 0, 0);
    end
    clr(); put(8'h90); put(8'h66); fire(1'b0);
    expect_all("R2 trailing prefix", 0, 1'b0, 8'h90, 0, 0, 0, 0);

    // R5 R6 R7 R9 sweep: every ModR/M, two SIB bases, size prefixes, both defaults
    for (int d = 0; d < 2; d++)
      for (int pf = 0; pf < 4; pf++)
        for (int oi = 0; oi < 2; oi++)
          for (int m = 0; m < 256; m++)
            for (int sv = 0; sv < 2; sv++) begin
              logic [7:0] op, sbyte;
              bit a16, o16;
              int imm;
              op    = (oi == 1) ? 8'h81 : 8'h01;
              sbyte = (sv == 1) ? 8'h05 : 8'h20;
              a16   = (d == 1) ^ pf[1];
              o16   = (d == 1) ^ pf[0];
              imm   = (oi == 1) ? (o16 ? 2 : 4) : 0;
              clr();
              if (pf[0]) put(8'h66);
              if (pf[1]) put(8'h67);
              put(op); put(8'(m)); put(sbyte);
              fire(d[0]);
              addr_model(8'(m), sbyte, a16, sb, dsp);
              expect_all("R5 R6 R7 R9 sweep", int'(pf[0]) + int'(pf[1]), 1'b0, op,
                         1'b1, sb, dsp, imm);
            end

    // R3 two-byte map
    clr(); put(8'h0F); put(8'h84); fire(0);
    expect_all("R3 R9 jcc rel", 0, 1, 8'h84, 0, 0, 0, 4);
    clr(); put(8'h66); put(8'h0F); put(8'h84); fire(0);
    expect_all("R3 R9 jcc rel16", 1, 1, 8'h84, 0, 0, 0, 2);
    clr(); put(8'h0F); put(8'hAF); put(8'hC0); fire(0);
    expect_all("R3 R4 imul", 0, 1, 8'hAF, 1, 0, 0, 0);
    clr(); put(8'h0F); put(8'hBA); put(8'hE0); put(8'h05); fire(0);
    expect_all("R3 R8 bt imm", 0, 1, 8'hBA, 1, 0, 0, 1);
    clr(); put(8'h0F); put(8'hA2); fire(0);
    expect_all("R3 R4 no modrm", 0, 1, 8'hA2, 0, 0, 0, 0);
    clr(); put(8'h0F); put(8'h31); fire(0);
    expect_all("R3 R4 row 3x", 0, 1, 8'h31, 0, 0, 0, 0);

    // R4 one-byte ModR/M classes
    clr(); put(8'h8D); put(8'h45); put(8'h08); fire(0);
    expect_all("R4 R5 lea disp8", 0, 0, 8'h8D, 1, 0, 1, 0);
    clr(); put(8'h03); put(8'hC1); fire(0);
    expect_all("R4 alu", 0, 0, 8'h03, 1, 0, 0, 0);
    clr(); put(8'hD9); put(8'hC0); fire(0);
    expect_all("R4 escape", 0, 0, 8'hD9, 1, 0, 0, 0);
    clr(); put(8'hFE); put(8'hC0); fire(0);
    expect_all("R4 group", 0, 0, 8'hFE, 1, 0, 0, 0);

    // R8 R9 immediates
    clr(); put(8'h05); fire(0);
    expect_all("R9 alu eax", 0, 0, 8'h05, 0, 0, 0, 4);
    clr(); put(8'h24); fire(0);
    expect_all("R8 alu al", 0, 0, 8'h24, 0, 0, 0, 1);
    clr(); put(8'hBB); fire(0);
    expect_all("R9 mov reg", 0, 0, 8'hBB, 0, 0, 0, 4);
    clr(); put(8'h66); put(8'hBB); fire(0);
    expect_all("R9 mov reg16", 1, 0, 8'hBB, 0, 0, 0, 2);
    clr(); put(8'hBB); fire(1);
    expect_all("R9 mov reg def16", 0, 0, 8'hBB, 0, 0, 0, 2);
    clr(); put(8'h70); fire(0);
    expect_all("R8 jcc8", 0, 0, 8'h70, 0, 0, 0, 1);
    clr(); put(8'hEB); fire(0);
    expect_all("R8 jmp8", 0, 0, 8'hEB, 0, 0, 0, 1);
    clr(); put(8'hC2); fire(0);
    expect_all("R8 ret imm", 0, 0, 8'hC2, 0, 0, 0, 2);
    clr(); put(8'h66); put(8'hCA); fire(0);
    expect_all("R8 retf imm", 1, 0, 8'hCA, 0, 0, 0, 2);
    clr(); put(8'hC8); fire(0);
    expect_all("R8 enter", 0, 0, 8'hC8, 0, 0, 0, 3);
    clr(); put(8'h9A); fire(0);
    expect_all("R9 far", 0, 0, 8'h9A, 0, 0, 0, 6);
    clr(); put(8'h66); put(8'hEA); fire(0);
    expect_all("R9 far16", 1, 0, 8'hEA, 0, 0, 0, 4);
    clr(); put(8'h6A); fire(0);
    expect_all("R8 push8", 0, 0, 8'h6A, 0, 0, 0, 1);
    clr(); put(8'hCD); fire(0);
    expect_all("R8 int", 0, 0, 8'hCD, 0, 0, 0, 1);

    // R12 reg-field dependent immediates
    clr(); put(8'hF6); put(8'hC0); fire(0);
    expect_all("R12 f6 reg0", 0, 0, 8'hF6, 1, 0, 0, 1);
    clr(); put(8'hF6); put(8'hD0); fire(0);
    expect_all("R12 f6 reg2", 0, 0, 8'hF6, 1, 0, 0, 0);
    clr(); put(8'hF7); put(8'hC0); fire(0);
    expect_all("R12 f7 reg0", 0, 0, 8'hF7, 1, 0, 0, 4);
    clr(); put(8'h66); put(8'hF7); put(8'hC0); fire(0);
    expect_all("R12 f7 reg0 16", 1, 0, 8'hF7, 1, 0, 0, 2);
    clr(); put(8'hF7); put(8'hD8); fire(0);
    expect_all("R12 f7 reg3", 0, 0, 8'hF7, 1, 0, 0, 0);

    // R10 absolute address forms
    clr(); put(8'hA1); fire(0);
    expect_all("R10 moffs32", 0, 0, 8'hA1, 0, 0, 4, 0);
    clr(); put(8'h67); put(8'hA1); fire(0);
    expect_all("R10 moffs16", 1, 0, 8'hA1, 0, 0, 2, 0);
    clr(); put(8'hA2); fire(1);
    expect_all("R10 moffs def16", 0, 0, 8'hA2, 0, 0, 2, 0);

    // R11 length limit boundary
    for (int p = 4; p <= 5; p++) begin
      clr();
      for (int j = 0; j < p; j++) put(8'hF0);
      put(8'h81); put(8'h84); put(8'h20);
      fire(0);
      expect_all("R11 limit", p, 0, 8'h81, 1, 1, 4, 4);
    end
    clr();
    for (int j = 0; j < 14; j++) put(8'h2E);
    put(8'h0F);
    fire(0);
    expect_all("R11 escape at end", 14, 1, 8'h00, 1, 0, 0, 0);

    // R1 hold while strobe low
    clr(); put(8'hBB); fire(0);
    expect_all("R1 load", 0, 0, 8'hBB, 0, 0, 0, 4);
    i_win = {WB{8'h90}};
    repeat (2) @(negedge clk);
    total++;
    if (o_vld !== 1'b0 || o_len !== 4'd5 || o_opcode !== 8'hBB) begin
      bad++;
      $display("FAIL R1 hold: got vld=%0b len=%0d op=%h exp 0 5 bb", o_vld, o_len, o_opcode);
    end

    report();
  end

endmodule